// File: doc/BRIEF.md
# Streaming Eight-Point Inverse Cosine Transform

This block computes an eight-point one-dimensional inverse discrete cosine transform entirely in hardware. Eight coefficient words enter through a valid/ready stream, and eight sample words leave through a second valid/ready stream of the same format. Both nested loops of the software form are flattened into a parallel set of dot products, one per output, each built from a fixed table of 64 fixed-point cosine weights. The processor has no per-element work to do.

Because the output word format matches the input word format, the block can sit behind a processor stream port, a memory streaming engine or another accelerator without change. The output of one instance can also drive the input of a second instance. A parameter chooses between a purely combinational row datapath and a variant that registers the eight results before they are emitted.

Top module: `idct_stream_1d`

## Requirements
- R1: A stream word is 32 bits wide. The input sample is the signed 16-bit value in bits 15:0, and bits 31:16 of an input word are ignored. Each output word carries a signed 16-bit result in bits 15:0, sign-extended into bits 31:16.
- R2: The block accepts input words while it holds fewer than 8 of them. Once 8 are held, in_ready stays low until the eighth result has been accepted downstream. After that, in_ready returns high and out_valid goes low.
- R3: Output x equals (sum over u of K[x][u]·X[u] + 8192) arithmetically shifted right by 14, truncated to 16 bits. K[x][u] = round(8192·cos((2x+1)uπ/16)) for u>0, and K[x][0] = round(8192/√2) = 5793. The sum is formed at 32 bits.
- R4: Results are emitted in index order, output 0 first and output 7 last. Input word k of a block is coefficient X[k].
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R6: A synchronous reset clears the input and output counters and discards a partly collected block. The next 8 words form a fresh block.
- R7: After reset, in_ready is high and out_valid is low.
- R8: No output is offered before all 8 words of a block have been accepted. Gaps in in_valid between words do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_data | input | 32 | Input word, coefficient in bits 15:0 |
| in_ready | output | 1 | Block can take an input word |
| out_valid | output | 1 | Output word offered |
| out_data | output | 32 | Output word, sign-extended result |
| out_ready | input | 1 | Downstream takes the output word |

## Verification
An all-zero block shows that no bias is added. A lone DC term checks the 1/√2 column weight and the rounding. Single impulses at each coefficient index isolate one column of the weight table at a time, which separates sign and folding errors per column. Full-scale positive and negative blocks exercise the 32-bit sum and the 16-bit truncation. Random blocks with garbage in the upper input half, irregular input gaps and random downstream stalls separate mixing between lanes, output ordering and hold behaviour. A reset in the middle of a block shows that stale words are discarded.

// File: rtl/idct_pkg.sv
package idct_pkg;

   localparam int COEF_W    = 16;
   localparam int COEF_FRAC = 14;
   localparam int POINTS    = 8;

   // Half-scaled cosine magnitudes for angles k*pi/16, k = 0..8, in Q1.14
   function automatic int cos_mag(input int k);
      case (k)
         0:       return 8192;
         1:       return 8035;
         2:       return 7568;
         3:       return 6811;
         4:       return 5793;
         5:       return 4551;
         6:       return 3135;
         7:       return 1598;
         default: return 0;
      endcase
   endfunction

   // Weight for output index x and coefficient index u, folded from the
   // cosine quadrant symmetry instead of a stored 64-entry table
   function automatic logic signed [COEF_W-1:0] weight(input int x, input int u);
      int m;
      int v;
      m = ((2 * x + 1) * u) % 32;
      if (m > 16) m = 32 - m;
      if (u == 0)      v = 5793;
      else if (m <= 8) v = cos_mag(m);
      else             v = -cos_mag(16 - m);
      return COEF_W'(v);
   endfunction

endpackage

// File: rtl/idct_gather.sv
module idct_gather #(
   parameter int N      = 8,
   parameter int DATA_W = 32,
   parameter int SAMP_W = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [DATA_W-1:0]          in_data,
   output logic                       in_ready,
   input  logic                       release_i,
   output logic [N-1:0][SAMP_W-1:0]   samp_o,
   output logic                       full_o
);
   localparam int CNT_W = $clog2(N + 1);
   localparam int IDX_W = $clog2(N);

   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign full_o   = (cnt_q == CNT_W'(N));
   assign in_ready = !full_o;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (release_i) begin
         cnt_q <= '0;
      end else if (take) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (take) samp_o[cnt_q[IDX_W-1:0]] <= in_data[SAMP_W-1:0];
   end

   generate
      if (DATA_W > SAMP_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^in_data[DATA_W-1:SAMP_W];
      end
   endgenerate

   p_fill_stop_r2: assert property (@(posedge clk) disable iff (rst)
      (take && cnt_q == CNT_W'(N - 1) && !release_i) |=> !in_ready);

   p_hold_full_r2: assert property (@(posedge clk) disable iff (rst)
      (!in_ready && !release_i) |=> !in_ready);

endmodule

// File: rtl/idct_row.sv
module idct_row #(
   parameter int N         = 8,
   parameter int SAMP_W    = 16,
   parameter int ACC_W     = 32,
   parameter int ROW_STYLE = 0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       start,
   input  logic                       clear,
   input  logic [N-1:0][SAMP_W-1:0]   samp,
   output logic [N-1:0][SAMP_W-1:0]   res,
   output logic                       res_ok
);
   import idct_pkg::*;

   logic [N-1:0][SAMP_W-1:0] comb_res;

   genvar x;
   generate
      for (x = 0; x < N; x++) begin : g_lane
         logic signed [ACC_W-1:0] acc;
         logic signed [ACC_W-1:0] scaled;
         always_comb begin
            acc = ACC_W'(1) <<< (COEF_FRAC - 1);
            for (int u = 0; u < N; u++) begin
               acc = acc + ACC_W'(weight(x, u)) * ACC_W'($signed(samp[u]));
            end
            scaled = acc >>> COEF_FRAC;
         end
         assign comb_res[x] = scaled[SAMP_W-1:0];
      end

      if (ROW_STYLE == 0) begin : g_comb
         logic unused_ctl;
         assign unused_ctl = clk ^ rst ^ clear;
         assign res    = comb_res;
         assign res_ok = start;
      end else begin : g_reg
         logic [N-1:0][SAMP_W-1:0] res_q;
         logic                     ok_q;
         always_ff @(posedge clk) begin
            if (rst || clear) begin
               ok_q <= 1'b0;
            end else if (start && !ok_q) begin
               ok_q <= 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (start && !ok_q) res_q <= comb_res;
         end
         assign res    = res_q;
         assign res_ok = ok_q;

         p_result_follows_r8: assert property (@(posedge clk) disable iff (rst)
            (start && !ok_q && !clear) |=> ok_q);
      end
   endgenerate

endmodule

// File: rtl/idct_emit.sv
module idct_emit #(
   parameter int N      = 8,
   parameter int DATA_W = 32,
   parameter int SAMP_W = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       res_ok,
   input  logic [N-1:0][SAMP_W-1:0]   res,
   input  logic                       out_ready,
   output logic                       out_valid,
   output logic [DATA_W-1:0]          out_data,
   output logic                       release_o
);
   localparam int IDX_W = $clog2(N);

   logic [IDX_W-1:0] idx_q;
   logic             fire;
   logic             last;

   assign out_valid = res_ok;
   assign out_data  = DATA_W'($signed(res[idx_q]));
   assign fire      = out_valid && out_ready;
   assign last      = (idx_q == IDX_W'(N - 1));
   assign release_o = fire && last;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
      end else if (fire) begin
         idx_q <= last ? '0 : idx_q + IDX_W'(1);
      end
   end

   p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   p_index_step_r4: assert property (@(posedge clk) disable iff (rst)
      (fire && !last) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

endmodule

// File: rtl/idct_stream_1d.sv
module idct_stream_1d #(
   parameter int DATA_W    = 32,
   parameter int SAMP_W    = 16,
   parameter int ACC_W     = 32,
   parameter int ROW_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);
   import idct_pkg::*;

   localparam int N = POINTS;

   generate
      if (DATA_W < SAMP_W) begin : g_bad_width
         $error("stream word narrower than sample");
      end
      if (ACC_W < SAMP_W + COEF_W) begin : g_bad_acc
         $error("accumulator too narrow for products");
      end
      if (ROW_STYLE != 0 && ROW_STYLE != 1) begin : g_bad_style
         $error("ROW_STYLE must be 0 or 1");
      end
   endgenerate

   logic [N-1:0][SAMP_W-1:0] samp;
   logic [N-1:0][SAMP_W-1:0] res;
   logic                     full;
   logic                     res_ok;
   logic                     done;

   idct_gather #(.N(N), .DATA_W(DATA_W), .SAMP_W(SAMP_W)) u_gather (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .release_i(done), .samp_o(samp), .full_o(full)
   );

   idct_row #(.N(N), .SAMP_W(SAMP_W), .ACC_W(ACC_W), .ROW_STYLE(ROW_STYLE)) u_row (
      .clk(clk), .rst(rst), .start(full), .clear(done), .samp(samp),
      .res(res), .res_ok(res_ok)
   );

   idct_emit #(.N(N), .DATA_W(DATA_W), .SAMP_W(SAMP_W)) u_emit (
      .clk(clk), .rst(rst), .res_ok(res_ok), .res(res), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .release_o(done)
   );

   p_phase_excl_r2: assert property (@(posedge clk) disable iff (rst)
      !(in_ready && out_valid));

   p_release_reopen_r2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && done) |=> (in_ready && !out_valid));

endmodule

// File: tb/idct_stream_1d_tb.sv
module idct_stream_1d_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] in_data;
   logic        in_ready;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_ready;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   idct_stream_1d u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Expected output x from the requirement formula (R3), weights from real math
   function automatic logic [31:0] model(input int x, input logic [31:0] w[8]);
      longint acc;
      int     k;
      logic [15:0] lo;
      acc = 8192;
      for (int u = 0; u < 8; u++) begin
         if (u == 0) k = int'(8192.0 / $sqrt(2.0));
         else        k = int'(8192.0 * $cos((2.0 * x + 1.0) * u * 3.14159265358979 / 16.0));
         acc += longint'(k) * longint'($signed(w[u][15:0]));
      end
      acc = acc >>> 14;
      lo = acc[15:0];
      return {{16{lo[15]}}, lo};
   endfunction

   task automatic send_words(input logic [31:0] w[8], input int cnt, input bit gaps,
                             output bit early);
      early = 1'b0;
      for (int i = 0; i < cnt; i++) begin
         if (gaps) repeat ($urandom % 3) @(negedge clk);
         @(negedge clk);
         if (out_valid) early = 1'b1;
         in_valid = 1'b1;
         in_data  = w[i];
         while (!in_ready) @(negedge clk);
         @(posedge clk);
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = $urandom;
      end
   endtask

   task automatic run_block(input logic [31:0] w[8], input bit gaps, input bit bp);
      bit          early;
      bit          got;
      bit          stalled;
      bit          seen_first;
      logic [31:0] held;
      logic [31:0] exp;
      send_words(w, 8, gaps, early);
      check(!early, "R8 no output before full block", {31'd0, early}, 32'd0);
      seen_first = 1'b0;
      for (int x = 0; x < 8; x++) begin
         got = 1'b0;
         stalled = 1'b0;
         exp = model(x, w);
         while (!got) begin
            @(negedge clk);
            out_ready = bp ? 1'($urandom % 2) : 1'b1;
            if (out_valid) begin
               if (!seen_first) begin
                  seen_first = 1'b1;
                  check(!in_ready, "R2 in_ready low while block held",
                        {31'd0, in_ready}, 32'd0);
               end
               if (stalled)
                  check(out_data === held, "R5 data stable under stall", out_data, held);
               if (out_ready) begin
                  check(out_data === exp, $sformatf("R3/R4 output %0d", x), out_data, exp);
                  got = 1'b1;
               end else begin
                  stalled = 1'b1;
                  held = out_data;
               end
            end
         end
      end
      @(negedge clk);
      out_ready = 1'b0;
      check(in_ready && !out_valid, "R2 reopen after last result",
            {30'd0, in_ready, out_valid}, 32'd2);
   endtask

   initial begin
      logic [31:0] blk[8];
      bit          early;
      void'($urandom(32'd1234));
      rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
      fork
         begin
            repeat (3) @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            check(in_ready && !out_valid, "R7 reset state",
                  {30'd0, in_ready, out_valid}, 32'd2);

            foreach (blk[i]) blk[i] = 32'd0;
            run_block(blk, 1'b0, 1'b0);                  // zero block

            foreach (blk[i]) blk[i] = 32'd0;
            blk[0] = 32'd1000;
            run_block(blk, 1'b0, 1'b0);                  // DC only

            for (int u = 0; u < 8; u++) begin            // impulses per column
               foreach (blk[i]) blk[i] = 32'd0;
               blk[u] = (u % 2) ? 32'hFFFF_F000 : 32'd4096;
               run_block(blk, 1'b1, 1'b1);
            end

            foreach (blk[i]) blk[i] = 32'h0000_7FFF;     // full-scale positive
            run_block(blk, 1'b0, 1'b1);
            foreach (blk[i]) blk[i] = 32'hFFFF_8000;     // full-scale negative
            run_block(blk, 1'b0, 1'b1);

            // R1: garbage in the upper half must not matter
            foreach (blk[i]) blk[i] = {16'hA5C3, 16'(i * 700 - 2000)};
            run_block(blk, 1'b1, 1'b0);

            // R6: partial block discarded by reset
            foreach (blk[i]) blk[i] = 32'd9999;
            send_words(blk, 3, 1'b0, early);
            @(negedge clk); rst = 1'b1;
            @(negedge clk); rst = 1'b0;
            @(negedge clk);
            check(in_ready && !out_valid, "R6 counters cleared by reset",
                  {30'd0, in_ready, out_valid}, 32'd2);
            foreach (blk[i]) blk[i] = 32'(i * 321 - 1100);
            run_block(blk, 1'b1, 1'b1);

            for (int t = 0; t < 20; t++) begin           // random blocks
               foreach (blk[i]) blk[i] = $urandom;
               run_block(blk, 1'b1, 1'b1);
            end
         end
         begin
            repeat (150000) @(posedge clk);
            check(1'b0, "watchdog expired", 32'd0, 32'd1);
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule